// File: doc/BRIEF.md
# Video Active-Window and Line-Drop Generator

This block watches an active-low horizontal sync and an active-low vertical sync on a pixel clock. From them it derives a display-enable flag that marks where a reduced-resolution panel should take video. It counts clocks since the last horizontal sync falling edge and lines since the last vertical sync falling edge. It also works out whether the current field is odd or even from where in the line the vertical sync edge landed.

Three timing standards are supported: a 525-line style, a 625-line style, and an external-clock style in which the horizontal window is counted in clocks. A sampling-width input chooses between a wide and a narrow horizontal window in every standard. In the 625-line style a fixed, periodic set of lines is left out of the picture, and the pattern differs between the two fields. This lets the panel's shorter column fit the taller raster.

Top module: `vid_window_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `pix_cnt`, `line_cnt`, `field_even` and `de` are all cleared to zero.
- R2: A horizontal sync falling edge is a clock where `hsync_n` is low and was high at the previous clock. That clock sets `pix_cnt` to 0. Every other clock raises it by one, and it saturates at its all-ones value.
- R3: A vertical sync falling edge, detected the same way on `vsync_n`, sets `line_cnt` to 0. Otherwise each horizontal sync falling edge raises it by one, saturating at all ones, and it holds at all other clocks.
- R4: At each vertical sync falling edge, let `p` be `pix_cnt` just before the edge and `L` the length of the last complete line in clocks. `field_even` becomes 1 when 4·p ≥ L and 4·p < 3·L, and becomes 0 otherwise. Before any line has been measured, L is 0.
- R5: `field_even` does not change except at a vertical sync falling edge.
- R6: In the 525-line style (`pal_sel`=0, `ext_clk_sel`=0), only lines 20 to 253 inclusive can be enabled.
- R7: In the 625-line style (`pal_sel`=1, `ext_clk_sel`=0), only lines 26 to 298 inclusive can be enabled.
- R8: In the 625-line style, `de` stays low on the dropped lines. For n = 1 to 20, these are lines 14n+12 and 14n+20 when `field_even`=1, and lines 14n+17 and 14n+23 when `field_even`=0.
- R9: `de` can be high only while `pix_cnt` lies inside the inclusive horizontal window. The window is set by parameters for each style, with the wide bounds used when `sam_hi`=1 and the narrow bounds when `sam_hi`=0.
- R10: With `ext_clk_sel`=1, the external-clock horizontal bounds apply, the 525-line vertical range applies whatever `pal_sel` is, and no lines are dropped.
- R11: `de` is registered. At each edge it takes the AND of the horizontal window, the vertical window and not-dropped, all judged on the counters and field flag before that edge. It stays low until a vertical sync pulse has both fallen and risen after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| pal_sel | input | 1 | 1 selects the 625-line style |
| ext_clk_sel | input | 1 | 1 selects the external-clock style |
| sam_hi | input | 1 | 1 selects the wide horizontal window, 0 the narrow one |
| de | output | 1 | Registered display enable |
| pix_cnt | output | PIX_W | Clocks since the last horizontal sync falling edge |
| line_cnt | output | LINE_W | Lines since the last vertical sync falling edge |
| field_even | output | 1 | 1 for the even field |

## Verification
The bench builds the block with small horizontal bounds, all under 40 clocks, for every style and width setting. With 40-clock lines, whole 262-line and 312-line fields fit in the run. Every clock of every field is compared against an arithmetic model, so both vertical ranges and every dropped line in both fields are covered, as are all six horizontal windows. Odd fields put the vertical edge on a horizontal edge and even fields put it mid-line, which exercises both outcomes of the parity rule, including the very first field, when no line has been measured yet.

// File: rtl/vwg_pkg.sv
package vwg_pkg;

  typedef enum logic [1:0] {
    STD_525 = 2'd0,
    STD_625 = 2'd1,
    STD_EXT = 2'd2
  } vstd_e;

  localparam int unsigned V525_FIRST  = 20;
  localparam int unsigned V525_LAST   = 253;
  localparam int unsigned V625_FIRST  = 26;
  localparam int unsigned V625_LAST   = 298;

  localparam int unsigned DROP_STEP   = 14;
  localparam int unsigned DROP_N_LO   = 1;
  localparam int unsigned DROP_N_HI   = 20;
  localparam int unsigned EVN_OFS_A   = 12;
  localparam int unsigned EVN_OFS_B   = 20;
  localparam int unsigned ODD_OFS_A   = 17;
  localparam int unsigned ODD_OFS_B   = 23;

  function automatic logic in_span(int unsigned v, int unsigned lo, int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

  function automatic logic on_comb(int unsigned line, int unsigned ofs);
    if (line < ofs + DROP_STEP * DROP_N_LO) return 1'b0;
    if (line > ofs + DROP_STEP * DROP_N_HI) return 1'b0;
    return ((line - ofs) % DROP_STEP) == 0;
  endfunction

  function automatic logic line_dropped(int unsigned line, logic even);
    if (even) return on_comb(line, EVN_OFS_A) || on_comb(line, EVN_OFS_B);
    return on_comb(line, ODD_OFS_A) || on_comb(line, ODD_OFS_B);
  endfunction

  function automatic logic edge_mid_line(int unsigned pos, int unsigned len);
    return (4 * pos >= len) && (4 * pos < 3 * len);
  endfunction

endpackage

// File: rtl/vwg_edges.sv
module vwg_edges (
  input  logic clk,
  input  logic rst,
  input  logic hsync_n,
  input  logic vsync_n,
  output logic hs_fall,
  output logic vs_fall,
  output logic vs_rise
);
  logic hs_q, vs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= 1'b1;
      vs_q <= 1'b1;
    end else begin
      hs_q <= hsync_n;
      vs_q <= vsync_n;
    end
  end

  assign hs_fall = hs_q & ~hsync_n;
  assign vs_fall = vs_q & ~vsync_n;
  assign vs_rise = ~vs_q & vsync_n;

  AST_HS_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    hs_fall |=> !hs_fall); // R2
  AST_VS_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    vs_fall |=> !vs_fall); // R3
endmodule

// File: rtl/vwg_counters.sv
module vwg_counters #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_fall,
  input  logic              vs_fall,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_cnt,
  output logic              field_even
);
  import vwg_pkg::*;

  localparam logic [PIX_W-1:0]  PIX_MAX  = '1;
  localparam logic [PIX_W-1:0]  PIX_ONE  = PIX_W'(1);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;
  localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

  logic [PIX_W-1:0] last_len;
  logic [PIX_W-1:0] pix_next_len;
  logic             parity_mid;

  assign pix_next_len = (pix_cnt == PIX_MAX) ? pix_cnt : pix_cnt + PIX_ONE;
  assign parity_mid   = edge_mid_line(32'(pix_cnt), 32'(last_len));

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_cnt    <= '0;
      line_cnt   <= '0;
      last_len   <= '0;
      field_even <= 1'b0;
    end else begin
      pix_cnt <= hs_fall ? '0 : pix_next_len;
      if (hs_fall) last_len <= pix_next_len;
      if (vs_fall)
        line_cnt <= '0;
      else if (hs_fall && line_cnt != LINE_MAX)
        line_cnt <= line_cnt + LINE_ONE;
      if (vs_fall) field_even <= parity_mid;
    end
  end

  AST_PIX_RESTART: assert property (@(posedge clk) disable iff (rst)
    hs_fall |=> pix_cnt == '0); // R2
  AST_PIX_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!hs_fall && pix_cnt != PIX_MAX) |=> pix_cnt == $past(pix_cnt) + PIX_ONE); // R2
  AST_LINE_RESTART: assert property (@(posedge clk) disable iff (rst)
    vs_fall |=> line_cnt == '0); // R3
  AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (hs_fall && !vs_fall && line_cnt != LINE_MAX) |=> line_cnt == $past(line_cnt) + LINE_ONE); // R3
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!hs_fall && !vs_fall) |=> $stable(line_cnt)); // R3
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !vs_fall |=> $stable(field_even)); // R5
endmodule

// File: rtl/vwg_window.sv
module vwg_window #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 10,
  parameter int H525_WIDE_LO   = 244,
  parameter int H525_WIDE_HI   = 1260,
  parameter int H525_NARROW_LO = 246,
  parameter int H525_NARROW_HI = 1258,
  parameter int H625_WIDE_LO   = 260,
  parameter int H625_WIDE_HI   = 1276,
  parameter int H625_NARROW_LO = 262,
  parameter int H625_NARROW_HI = 1274,
  parameter int HEXT_WIDE_LO   = 205,
  parameter int HEXT_WIDE_HI   = 1164,
  parameter int HEXT_NARROW_LO = 84,
  parameter int HEXT_NARROW_HI = 403
) (
  input  logic                clk,
  input  logic                rst,
  input  vwg_pkg::vstd_e      vstd,
  input  logic                sam_hi,
  input  logic [PIX_W-1:0]    pix_cnt,
  input  logic [LINE_W-1:0]   line_cnt,
  input  logic                field_even,
  input  logic                vs_fall,
  input  logic                vs_rise,
  output logic                de
);
  import vwg_pkg::*;

  int unsigned h_lo, h_hi;
  logic h_act, v_act, drop_hit, seen_vfall, armed, de_next;

  always_comb begin
    unique case (vstd)
      STD_625: begin
        h_lo = sam_hi ? H625_WIDE_LO : H625_NARROW_LO;
        h_hi = sam_hi ? H625_WIDE_HI : H625_NARROW_HI;
      end
      STD_EXT: begin
        h_lo = sam_hi ? HEXT_WIDE_LO : HEXT_NARROW_LO;
        h_hi = sam_hi ? HEXT_WIDE_HI : HEXT_NARROW_HI;
      end
      default: begin
        h_lo = sam_hi ? H525_WIDE_LO : H525_NARROW_LO;
        h_hi = sam_hi ? H525_WIDE_HI : H525_NARROW_HI;
      end
    endcase
  end

  assign h_act    = in_span(32'(pix_cnt), h_lo, h_hi);
  assign v_act    = (vstd == STD_625) ? in_span(32'(line_cnt), V625_FIRST, V625_LAST)
                                      : in_span(32'(line_cnt), V525_FIRST, V525_LAST);
  assign drop_hit = (vstd == STD_625) && line_dropped(32'(line_cnt), field_even);
  assign de_next  = armed && h_act && v_act && !drop_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_vfall <= 1'b0;
      armed      <= 1'b0;
      de         <= 1'b0;
    end else begin
      if (vs_fall) seen_vfall <= 1'b1;
      if (seen_vfall && vs_rise) armed <= 1'b1;
      de <= de_next;
    end
  end

  AST_DE_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !de); // R11
  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed); // R11
  AST_DE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    drop_hit |=> !de); // R8
  AST_DE_OUTSIDE_H: assert property (@(posedge clk) disable iff (rst)
    !h_act |=> !de); // R9
  AST_DE_OUTSIDE_V: assert property (@(posedge clk) disable iff (rst)
    !v_act |=> !de); // R6
endmodule

// File: rtl/vid_window_gen.sv
module vid_window_gen #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 10,
  parameter int H525_WIDE_LO   = 244,
  parameter int H525_WIDE_HI   = 1260,
  parameter int H525_NARROW_LO = 246,
  parameter int H525_NARROW_HI = 1258,
  parameter int H625_WIDE_LO   = 260,
  parameter int H625_WIDE_HI   = 1276,
  parameter int H625_NARROW_LO = 262,
  parameter int H625_NARROW_HI = 1274,
  parameter int HEXT_WIDE_LO   = 205,
  parameter int HEXT_WIDE_HI   = 1164,
  parameter int HEXT_NARROW_LO = 84,
  parameter int HEXT_NARROW_HI = 403
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync_n,
  input  logic              vsync_n,
  input  logic              pal_sel,
  input  logic              ext_clk_sel,
  input  logic              sam_hi,
  output logic              de,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_cnt,
  output logic              field_even
);
  import vwg_pkg::*;

  logic   hs_fall, vs_fall, vs_rise;
  vstd_e  vstd;

  assign vstd = ext_clk_sel ? STD_EXT : (pal_sel ? STD_625 : STD_525);

  vwg_edges u_edges (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .hs_fall(hs_fall), .vs_fall(vs_fall), .vs_rise(vs_rise)
  );

  vwg_counters #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_counters (
    .clk(clk), .rst(rst), .hs_fall(hs_fall), .vs_fall(vs_fall),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt), .field_even(field_even)
  );

  vwg_window #(
    .PIX_W(PIX_W), .LINE_W(LINE_W),
    .H525_WIDE_LO(H525_WIDE_LO), .H525_WIDE_HI(H525_WIDE_HI),
    .H525_NARROW_LO(H525_NARROW_LO), .H525_NARROW_HI(H525_NARROW_HI),
    .H625_WIDE_LO(H625_WIDE_LO), .H625_WIDE_HI(H625_WIDE_HI),
    .H625_NARROW_LO(H625_NARROW_LO), .H625_NARROW_HI(H625_NARROW_HI),
    .HEXT_WIDE_LO(HEXT_WIDE_LO), .HEXT_WIDE_HI(HEXT_WIDE_HI),
    .HEXT_NARROW_LO(HEXT_NARROW_LO), .HEXT_NARROW_HI(HEXT_NARROW_HI)
  ) u_window (
    .clk(clk), .rst(rst), .vstd(vstd), .sam_hi(sam_hi),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt), .field_even(field_even),
    .vs_fall(vs_fall), .vs_rise(vs_rise), .de(de)
  );

  AST_RESET_DE_LOW: assert property (@(posedge clk)
    rst |=> !de); // R1
  AST_EXT_NO_DROP_625V: assert property (@(posedge clk) disable iff (rst)
    (ext_clk_sel && line_cnt > LINE_W'(253)) |=> !de); // R10
endmodule

// File: tb/vid_window_gen_bench.sv
module vid_window_gen_bench;
  localparam int CLK_T    = 10;
  localparam int LINE_LEN = 40;
  localparam int HS_LOW   = 3;
  localparam int PW = 12;
  localparam int LW = 10;
  localparam int A_WLO = 8,  A_WHI = 35, A_NLO = 9,  A_NHI = 34;
  localparam int B_WLO = 9,  B_WHI = 36, B_NLO = 10, B_NHI = 35;
  localparam int E_WLO = 12, E_WHI = 37, E_NLO = 5,  E_NHI = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsync_n = 1'b1, vsync_n = 1'b1, pal_sel = 1'b0, ext_clk_sel = 1'b0, sam_hi = 1'b1;
  logic de, field_even;
  logic [PW-1:0] pix_cnt;
  logic [LW-1:0] line_cnt;

  int total = 0, bad = 0;
  int m_pix, m_line, m_len;
  logic m_even, m_arm, m_seen, m_h, m_v, m_de;

  always #(CLK_T/2) clk = ~clk;

  vid_window_gen #(
    .PIX_W(PW), .LINE_W(LW),
    .H525_WIDE_LO(A_WLO), .H525_WIDE_HI(A_WHI), .H525_NARROW_LO(A_NLO), .H525_NARROW_HI(A_NHI),
    .H625_WIDE_LO(B_WLO), .H625_WIDE_HI(B_WHI), .H625_NARROW_LO(B_NLO), .H625_NARROW_HI(B_NHI),
    .HEXT_WIDE_LO(E_WLO), .HEXT_WIDE_HI(E_WHI), .HEXT_NARROW_LO(E_NLO), .HEXT_NARROW_HI(E_NHI)
  ) u_vid_window_gen (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .pal_sel(pal_sel), .ext_clk_sel(ext_clk_sel), .sam_hi(sam_hi),
    .de(de), .pix_cnt(pix_cnt), .line_cnt(line_cnt), .field_even(field_even)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic logic b_hwin(int p);
    int lo, hi;
    if (ext_clk_sel) begin lo = sam_hi ? E_WLO : E_NLO; hi = sam_hi ? E_WHI : E_NHI; end
    else if (pal_sel) begin lo = sam_hi ? B_WLO : B_NLO; hi = sam_hi ? B_WHI : B_NHI; end
    else begin lo = sam_hi ? A_WLO : A_NLO; hi = sam_hi ? A_WHI : A_NHI; end
    return p >= lo && p <= hi;
  endfunction

  function automatic logic b_vwin(int l);
    if (pal_sel && !ext_clk_sel) return l >= 26 && l <= 298;
    return l >= 20 && l <= 253;
  endfunction

  function automatic logic b_drop(int l, logic ev);
    if (!pal_sel || ext_clk_sel) return 1'b0;
    for (int n = 1; n <= 20; n++) begin
      if (ev && (l == 14*n + 12 || l == 14*n + 20)) return 1'b1;
      if (!ev && (l == 14*n + 17 || l == 14*n + 23)) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic step(input logic h, input logic v);
    logic nde, hf, vf, vr;
    string dtag;
    nde = m_arm && b_hwin(m_pix) && b_vwin(m_line) && !b_drop(m_line, m_even);
    if (!m_arm) dtag = "R11";
    else if (b_drop(m_line, m_even)) dtag = "R8";
    else if (ext_clk_sel) dtag = "R10";
    else if (!b_vwin(m_line)) dtag = pal_sel ? "R7" : "R6";
    else if (!b_hwin(m_pix)) dtag = "R9";
    else dtag = "R11";
    hf = m_h & ~h; vf = m_v & ~v; vr = ~m_v & v;
    if (vf) m_even = (4*m_pix >= m_len) && (4*m_pix < 3*m_len);
    if (hf) m_len = (m_pix == 4095) ? 4095 : m_pix + 1;
    if (vf) m_line = 0; else if (hf && m_line != 1023) m_line++;
    m_pix = hf ? 0 : ((m_pix == 4095) ? 4095 : m_pix + 1);
    if (m_seen && vr) m_arm = 1'b1;
    if (vf) m_seen = 1'b1;
    m_de = nde;
    hsync_n = h; vsync_n = v; m_h = h; m_v = v;
    @(negedge clk);
    check("R2 pix_cnt", int'(pix_cnt), m_pix);
    check("R3 line_cnt", int'(line_cnt), m_line);
    check(vf ? "R4 field_even" : "R5 field_even", int'(field_even), int'(m_even));
    check({dtag, " de"}, int'(de), int'(m_de));
  endtask

  task automatic run_field(input int nlines, input logic even);
    for (int ln = 0; ln < nlines; ln++) begin
      for (int c = 0; c < LINE_LEN; c++) begin
        logic v;
        if (even) v = !((ln == 0 && c >= 20) || (ln >= 1 && ln < 4) || (ln == 4 && c < 20));
        else v = !(ln < 4);
        step(c < HS_LOW ? 1'b0 : 1'b1, v);
      end
    end
  endtask

  initial begin
    #(CLK_T * 190000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 de", int'(de), 0);
    check("R1 pix_cnt", int'(pix_cnt), 0);
    check("R1 line_cnt", int'(line_cnt), 0);
    check("R1 field_even", int'(field_even), 0);
    m_pix = 0; m_line = 0; m_len = 0; m_even = 1'b0;
    m_arm = 1'b0; m_seen = 1'b0; m_h = 1'b1; m_v = 1'b1; m_de = 1'b0;
    rst = 1'b0;
    // 525-line style, wide then narrow window
    pal_sel = 1'b0; ext_clk_sel = 1'b0; sam_hi = 1'b1;
    run_field(262, 1'b0);
    run_field(262, 1'b1);
    sam_hi = 1'b0;
    run_field(262, 1'b0);
    // 625-line style: both drop patterns, both widths
    pal_sel = 1'b1; sam_hi = 1'b1;
    run_field(312, 1'b0);
    run_field(312, 1'b1);
    sam_hi = 1'b0;
    run_field(312, 1'b1);
    // external-clock style ignores pal_sel for vertical range and drops (R10)
    ext_clk_sel = 1'b1; sam_hi = 1'b1;
    run_field(312, 1'b0);
    sam_hi = 1'b0;
    run_field(262, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule